// File: doc/BRIEF.md
# Next Trace Prediction Table

This block predicts the next trace for a block-based trace fetch front end. It keeps a global branch-history register. Each resolved branch shifts its taken/not-taken outcome into that register. Every cycle the block folds the history into a table index and a tag and reads one entry. It then registers a hit or miss result, together with an ordered list of block identifiers. On a hit, that list addresses a separate block storage array during the following fetch cycle. Prediction and fetch therefore occupy distinct cycles.

Entries hold small block identifiers, not instruction words. A path that repeats costs only a few bytes of identifiers in this table, and no copied instructions appear anywhere. The completion side of the pipeline writes entries through an update port. Each write carries the history that was in force and the blocks that actually executed, in fetch order.

Top module: `ntp_table`

## Requirements
- R1: While reset is held and after it is released, the history register is zero, every entry is invalid, and the outputs show a miss with zero count, zero slot-valid mask and zero identifiers.
- R2: Each cycle with `br_valid` high shifts `br_taken` into bit 0 of the 16-bit history, and every older bit moves up one position. With `br_valid` low the history is unchanged.
- R3: The table index is the 8-bit XOR of history bits [7:0] with bits [15:8]. The tag is history bits [13:8].
- R4: A hit requires a valid entry at the index whose stored tag equals the lookup tag. A history that maps to the same index but a different tag gives a miss.
- R5: On a hit, `pred_cnt` is the stored count (1 to 4). Slot i sits at `pred_bids[8*i+7:8*i]`, with slot 0 fetched first. `pred_slot_vld[i]` is high exactly for i below the count, and slots at or above the count read as zero.
- R6: `pred_hit` and `pred_miss` are never both high or both low. On a miss, the count, the mask and all identifiers are zero.
- R7: The registered result reflects the history and table contents as they stood in the previous cycle, so lookup latency is one clock.
- R8: An update writes tag, count and identifiers at the index derived from `upd_hist`, replacing any earlier entry there. A lookup in the same cycle still sees the old contents, and the new entry is visible from the next cycle onward.
- R9: An update whose `upd_cnt` is 0 or greater than 4 is discarded, and the entry it addresses stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch outcome is presented this cycle |
| br_taken | input | 1 | Outcome bit shifted into the history |
| upd_valid | input | 1 | Completion-side write request |
| upd_hist | input | 16 | History the written trace belongs to |
| upd_cnt | input | 3 | Number of identifiers in the written trace |
| upd_bids | input | 32 | Identifiers, slot 0 in bits [7:0] |
| pred_hit | output | 1 | Registered hit flag |
| pred_miss | output | 1 | Registered miss flag |
| pred_cnt | output | 3 | Number of predicted identifiers |
| pred_slot_vld | output | 4 | Per-slot valid mask |
| pred_bids | output | 32 | Predicted identifiers, slot 0 in bits [7:0] |

## Verification
A lookup result is due at the first rising edge after the cycle whose history and table state it reflects. A branch or an update therefore shows on the outputs one edge later than a lookup does: the state changes at one edge and the registered result follows at the next. The bench drives each stimulus on a falling edge and, at that moment, computes the expected result from its own model of history and table as they stand before the coming edge. It then applies the stimulus to the model. A monitor pops each expectation one nanosecond after the following rising edge, so every comparison lands in exactly the cycle the requirements place it.

// File: rtl/ntp_pkg.sv
package ntp_pkg;
    // Default geometry of the prediction table.
    localparam int unsigned NTP_HIST_W = 16;
    localparam int unsigned NTP_IDX_W  = 8;
    localparam int unsigned NTP_TAG_W  = 6;
    localparam int unsigned NTP_SLOTS  = 4;
    localparam int unsigned NTP_BID_W  = 8;
endpackage

// File: rtl/ntp_hist.sv
module ntp_hist #(
    parameter int unsigned HIST_W = ntp_pkg::NTP_HIST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist_o
);
    logic [HIST_W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
            hist_d = {hist_q[HIST_W-2:0], shift_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_o = hist_q;
endmodule

// File: rtl/ntp_hash.sv
module ntp_hash #(
    parameter int unsigned HIST_W = ntp_pkg::NTP_HIST_W,
    parameter int unsigned IDX_W  = ntp_pkg::NTP_IDX_W,
    parameter int unsigned TAG_W  = ntp_pkg::NTP_TAG_W
) (
    input  logic [HIST_W-1:0] hist_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [TAG_W-1:0]  tag_o
);
    localparam int unsigned HALF = HIST_W / 2;

    logic [HALF-1:0] fold;

    // Fold the two history halves together; index from the fold,
    // tag straight from the upper half so it separates aliasing histories.
    assign fold  = hist_i[HALF-1:0] ^ hist_i[2*HALF-1:HALF];
    assign idx_o = fold[IDX_W-1:0];
    assign tag_o = hist_i[HALF +: TAG_W];
endmodule

// File: rtl/ntp_store.sv
module ntp_store #(
    parameter int unsigned IDX_W = ntp_pkg::NTP_IDX_W,
    parameter int unsigned TAG_W = ntp_pkg::NTP_TAG_W,
    parameter int unsigned SLOTS = ntp_pkg::NTP_SLOTS,
    parameter int unsigned BID_W = ntp_pkg::NTP_BID_W,
    localparam int unsigned DEPTH = 1 << IDX_W,
    localparam int unsigned CNT_W = $clog2(SLOTS + 1),
    localparam int unsigned LIST_W = SLOTS * BID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic [LIST_W-1:0] wr_bids,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic [LIST_W-1:0] rd_bids
);
    logic [DEPTH-1:0]  vld_d, vld_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [CNT_W-1:0]  cnt_q  [DEPTH];
    logic [LIST_W-1:0] bids_q [DEPTH];

    always_comb begin
        vld_d = vld_q;
        if (wr_en) begin
            vld_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    // Payload needs no reset: it is only read behind a set valid bit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            cnt_q[wr_idx]  <= wr_cnt;
            bids_q[wr_idx] <= wr_bids;
        end
    end

    assign rd_vld  = vld_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_cnt  = cnt_q[rd_idx];
    assign rd_bids = bids_q[rd_idx];
endmodule

// File: rtl/ntp_resp.sv
module ntp_resp #(
    parameter int unsigned TAG_W = ntp_pkg::NTP_TAG_W,
    parameter int unsigned SLOTS = ntp_pkg::NTP_SLOTS,
    parameter int unsigned BID_W = ntp_pkg::NTP_BID_W,
    localparam int unsigned CNT_W = $clog2(SLOTS + 1),
    localparam int unsigned LIST_W = SLOTS * BID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_vld,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [CNT_W-1:0]  ent_cnt,
    input  logic [LIST_W-1:0] ent_bids,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit_o,
    output logic              miss_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [SLOTS-1:0]  slot_vld_o,
    output logic [LIST_W-1:0] bids_o
);
    typedef struct packed {
        logic              hit;
        logic              miss;
        logic [CNT_W-1:0]  cnt;
        logic [SLOTS-1:0]  sv;
        logic [LIST_W-1:0] bids;
    } resp_t;

    resp_t r_d, r_q;

    always_comb begin
        r_d      = '0;
        r_d.hit  = ent_vld && (ent_tag == look_tag);
        r_d.miss = !r_d.hit;
        if (r_d.hit) begin
            r_d.cnt = ent_cnt;
            for (int i = 0; i < SLOTS; i++) begin
                if (CNT_W'(i) < ent_cnt) begin
                    r_d.sv[i]                  = 1'b1;
                    r_d.bids[i*BID_W +: BID_W] = ent_bids[i*BID_W +: BID_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.miss <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign hit_o      = r_q.hit;
    assign miss_o     = r_q.miss;
    assign cnt_o      = r_q.cnt;
    assign slot_vld_o = r_q.sv;
    assign bids_o     = r_q.bids;
endmodule

// File: rtl/ntp_table.sv
module ntp_table #(
    parameter int unsigned HIST_W = ntp_pkg::NTP_HIST_W,
    parameter int unsigned IDX_W  = ntp_pkg::NTP_IDX_W,
    parameter int unsigned TAG_W  = ntp_pkg::NTP_TAG_W,
    parameter int unsigned SLOTS  = ntp_pkg::NTP_SLOTS,
    parameter int unsigned BID_W  = ntp_pkg::NTP_BID_W,
    localparam int unsigned CNT_W  = $clog2(SLOTS + 1),
    localparam int unsigned LIST_W = SLOTS * BID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic              br_taken,
    input  logic              upd_valid,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic [CNT_W-1:0]  upd_cnt,
    input  logic [LIST_W-1:0] upd_bids,
    output logic              pred_hit,
    output logic              pred_miss,
    output logic [CNT_W-1:0]  pred_cnt,
    output logic [SLOTS-1:0]  pred_slot_vld,
    output logic [LIST_W-1:0] pred_bids
);
    logic [HIST_W-1:0] hist_w;
    logic [IDX_W-1:0]  look_idx, wr_idx;
    logic [TAG_W-1:0]  look_tag, wr_tag;
    logic              wr_en;
    logic              ent_vld;
    logic [TAG_W-1:0]  ent_tag;
    logic [CNT_W-1:0]  ent_cnt;
    logic [LIST_W-1:0] ent_bids;

    ntp_hist #(.HIST_W(HIST_W)) hist_i (
        .clk(clk), .rst_n(rst_n),
        .shift_en(br_valid), .shift_bit(br_taken), .hist_o(hist_w)
    );

    ntp_hash #(.HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) look_hash_i (
        .hist_i(hist_w), .idx_o(look_idx), .tag_o(look_tag)
    );

    ntp_hash #(.HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) upd_hash_i (
        .hist_i(upd_hist), .idx_o(wr_idx), .tag_o(wr_tag)
    );

    // Only traces of 1..SLOTS blocks are accepted.
    assign wr_en = upd_valid && (upd_cnt != '0) && (upd_cnt <= CNT_W'(SLOTS));

    ntp_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .SLOTS(SLOTS), .BID_W(BID_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_cnt(upd_cnt), .wr_bids(upd_bids),
        .rd_idx(look_idx), .rd_vld(ent_vld), .rd_tag(ent_tag),
        .rd_cnt(ent_cnt), .rd_bids(ent_bids)
    );

    ntp_resp #(.TAG_W(TAG_W), .SLOTS(SLOTS), .BID_W(BID_W)) resp_i (
        .clk(clk), .rst_n(rst_n),
        .ent_vld(ent_vld), .ent_tag(ent_tag), .ent_cnt(ent_cnt),
        .ent_bids(ent_bids), .look_tag(look_tag),
        .hit_o(pred_hit), .miss_o(pred_miss), .cnt_o(pred_cnt),
        .slot_vld_o(pred_slot_vld), .bids_o(pred_bids)
    );
endmodule

// File: rtl/ntp_table_chk.sv
module ntp_table_chk #(
    parameter int unsigned HIST_W = 16,
    parameter int unsigned SLOTS  = 4,
    parameter int unsigned BID_W  = 8,
    localparam int unsigned CNT_W  = $clog2(SLOTS + 1),
    localparam int unsigned LIST_W = SLOTS * BID_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_valid,
    input logic              br_taken,
    input logic [HIST_W-1:0] hist_q,
    input logic              pred_hit,
    input logic              pred_miss,
    input logic [CNT_W-1:0]  pred_cnt,
    input logic [SLOTS-1:0]  pred_slot_vld,
    input logic [LIST_W-1:0] pred_bids
);
    p_hist_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (hist_q[0] == $past(br_taken)) &&
                     (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

    p_hist_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> $stable(hist_q));

    p_hit_xor_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit != pred_miss);

    p_miss_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pred_miss |-> (pred_cnt == '0) && (pred_slot_vld == '0) && (pred_bids == '0));

    p_mask_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> (pred_cnt != '0) && (pred_cnt <= CNT_W'(SLOTS)) &&
                     ($countones(pred_slot_vld) == int'(pred_cnt)));
endmodule

bind ntp_table ntp_table_chk #(.HIST_W(HIST_W), .SLOTS(SLOTS), .BID_W(BID_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
    .hist_q(hist_w), .pred_hit(pred_hit), .pred_miss(pred_miss),
    .pred_cnt(pred_cnt), .pred_slot_vld(pred_slot_vld), .pred_bids(pred_bids)
);

// File: tb/ntp_table_tb_top.sv
`timescale 1ns/1ps
module ntp_table_tb_top;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        br_valid, br_taken, upd_valid;
    logic [15:0] upd_hist;
    logic [2:0]  upd_cnt;
    logic [31:0] upd_bids;
    logic        pred_hit, pred_miss;
    logic [2:0]  pred_cnt;
    logic [3:0]  pred_slot_vld;
    logic [31:0] pred_bids;

    always #2.5 clk = ~clk;

    ntp_table dut_i (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
        .upd_valid(upd_valid), .upd_hist(upd_hist), .upd_cnt(upd_cnt),
        .upd_bids(upd_bids), .pred_hit(pred_hit), .pred_miss(pred_miss),
        .pred_cnt(pred_cnt), .pred_slot_vld(pred_slot_vld), .pred_bids(pred_bids)
    );

    typedef struct {
        logic        hit;
        logic        miss;
        logic [2:0]  cnt;
        logic [3:0]  sv;
        logic [31:0] bids;
        string       req;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_e;
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // Reference model state, built from the requirements.
    logic [15:0] m_hist;
    logic        m_v    [DEPTH];
    logic [5:0]  m_tag  [DEPTH];
    logic [2:0]  m_cnt  [DEPTH];
    logic [31:0] m_bids [DEPTH];

    function automatic logic [7:0] f_idx(input logic [15:0] h);
        return h[7:0] ^ h[15:8];          // R3 index
    endfunction

    function automatic logic [5:0] f_tag(input logic [15:0] h);
        return h[13:8];                   // R3 tag
    endfunction

    function automatic exp_t predict(input string req);
        exp_t e;
        logic [7:0] ix;
        ix     = f_idx(m_hist);
        e.hit  = m_v[ix] && (m_tag[ix] == f_tag(m_hist));
        e.miss = !e.hit;
        e.cnt  = '0;
        e.sv   = '0;
        e.bids = '0;
        e.req  = req;
        if (e.hit) begin
            e.cnt = m_cnt[ix];
            for (int i = 0; i < 4; i++) begin
                if (i < int'(m_cnt[ix])) begin
                    e.sv[i]          = 1'b1;
                    e.bids[i*8 +: 8] = m_bids[ix][i*8 +: 8];
                end
            end
        end
        return e;
    endfunction

    task automatic step(input logic bv, input logic bt, input logic uv,
                        input logic [15:0] uh, input logic [2:0] uc,
                        input logic [31:0] ub, input string req);
        @(negedge clk);
        br_valid  = bv;
        br_taken  = bt;
        upd_valid = uv;
        upd_hist  = uh;
        upd_cnt   = uc;
        upd_bids  = ub;
        sbq.push_back(predict(req));      // due one edge later (R7)
        if (bv) m_hist = {m_hist[14:0], bt};
        if (uv && uc >= 3'd1 && uc <= 3'd4) begin
            m_v[f_idx(uh)]    = 1'b1;
            m_tag[f_idx(uh)]  = f_tag(uh);
            m_cnt[f_idx(uh)]  = uc;
            m_bids[f_idx(uh)] = ub;
        end
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, 1'b0, 16'h0, 3'd0, 32'h0, req);
    endtask

    task automatic load_hist(input logic [15:0] h, input string req);
        for (int i = 15; i >= 0; i--) begin
            step(1'b1, h[i], 1'b0, 16'h0, 3'd0, 32'h0, req);
        end
    endtask

    task automatic write(input logic [15:0] h, input logic [2:0] c,
                         input logic [31:0] b, input string req);
        step(1'b0, 1'b0, 1'b1, h, c, b, req);
    endtask

    // Monitor: compare one expectation per edge, away from the edge.
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            mon_e = sbq.pop_front();
            n_chk++;
            if ({pred_hit, pred_miss, pred_cnt, pred_slot_vld, pred_bids} !==
                {mon_e.hit, mon_e.miss, mon_e.cnt, mon_e.sv, mon_e.bids}) begin
                n_fail++;
                $display("FAIL %s: got hit=%b miss=%b cnt=%0d sv=%b bids=%h exp hit=%b miss=%b cnt=%0d sv=%b bids=%h",
                         mon_e.req, pred_hit, pred_miss, pred_cnt, pred_slot_vld, pred_bids,
                         mon_e.hit, mon_e.miss, mon_e.cnt, mon_e.sv, mon_e.bids);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; br_valid = 1'b0; br_taken = 1'b0; upd_valid = 1'b0;
        upd_hist = '0; upd_cnt = '0; upd_bids = '0;
        m_hist = '0;
        for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        n_chk++;
        if ({pred_hit, pred_miss, pred_cnt, pred_slot_vld, pred_bids} !== {1'b0, 1'b1, 3'd0, 4'd0, 32'd0}) begin
            n_fail++;
            $display("FAIL R1: got hit=%b miss=%b cnt=%0d sv=%b bids=%h exp miss only",
                     pred_hit, pred_miss, pred_cnt, pred_slot_vld, pred_bids);
        end
        rst_n = 1'b1;

        idle("R1"); idle("R6"); idle("R6");

        // R8: write at history 0; same-cycle lookup sees old, then new
        write(16'h0000, 3'd4, 32'h04030201, "R8");
        idle("R8"); idle("R5");

        // R2/R5: partial trace reached by shifting the history in
        write(16'hA5C3, 3'd2, 32'hDDCCBBAA, "R8");
        load_hist(16'hA5C3, "R2");
        idle("R5"); idle("R5");

        // R3/R4: same index 0x26, different tags
        write(16'h1234, 3'd3, 32'h00302010, "R3");
        load_hist(16'h1335, "R4");
        idle("R4");
        load_hist(16'h3412, "R4");
        idle("R4");
        load_hist(16'h1234, "R3");
        idle("R3");

        // R9: bad counts leave the entry untouched
        write(16'h1234, 3'd0, 32'hFFFFFFFF, "R9");
        idle("R9");
        write(16'h1234, 3'd5, 32'hEEEEEEEE, "R9");
        idle("R9");
        write(16'h1234, 3'd7, 32'hEEEEEEEE, "R9");
        idle("R9");

        // R8/R5: overwrite with a one-block trace while looking it up
        write(16'h1234, 3'd1, 32'h000000EE, "R8");
        idle("R5"); idle("R5");

        // R7: branch cycle still shows old history, next cycle the new one
        step(1'b1, 1'b0, 1'b0, 16'h0, 3'd0, 32'h0, "R7");
        idle("R7"); idle("R6");

        // R7: branch and update together
        step(1'b1, 1'b1, 1'b1, 16'h48D1, 3'd4, 32'hA1B2C3D4, "R7");
        idle("R7"); idle("R7");

        idle("R6");
        @(negedge clk);
        repeat (2) @(negedge clk);
        n_chk++;
        if (sbq.size() != 0) begin
            n_fail++;
            $display("FAIL R7: got %0d pending results exp 0", sbq.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule